// File: doc/BRIEF.md
# Mapped Glitch-Free Clock Output Gate

This block sits between a set of eight free-running source clocks and the eight clock output pins of a clock generator. Three active-low enable pins control which outputs run. Each pin reaches any subset of the outputs through a configuration mask, so one output may answer to several pins. Any linked pin that asks for a stop wins.

Starting and stopping never produce a shortened pulse. A stop request lets the high phase already in progress finish, and a start request waits for a fresh rising edge of the source clock. Each request is first passed through a two-flop synchroniser in the output's own clock domain. While an output is stopped it rests in the level chosen for it: driven low, driven high, or released. A released output is modelled by a low drive-enable line for an external tri-state buffer.

A separate power-down bit per output holds an unused output quiet whatever the pins do. An output that has no linked pin runs freely.

Top module: `mapped_clock_gate`

## Requirements
- R1: An enable pin held low lets every output it is linked to run. Held high, it stops those outputs.
- R2: Bit `p*8+o` of `link_mask` links pin p to output o. A pin that is not linked to an output has no effect on it, and an output with no linked pin runs.
- R3: When several pins are linked to one output, the output stops if any one of them is high.
- R4: After a start request changes at a falling source edge, the high phase after the 2nd rising edge is still idle. The first output pulse is the whole high phase after the 3rd rising edge.
- R5: After a stop request changes at a falling source edge, the full high phases after the 1st and 2nd rising edges are still delivered. From the 3rd rising edge on, the output rests in its idle level.
- R6: `idle_sel` holds two bits per output (bits 2o+1:2o). Code 0 drives low while stopped, code 1 drives high, and codes 2 and 3 release the pin (`clk_drv_en` low, `clk_out` low). A running output has `clk_drv_en` high and is low during the low half of its source clock.
- R7: While `pwr_dn[o]` is set, output o has `clk_drv_en` and `clk_out` low in the same cycle, whatever the pins say. After it is cleared, the output restarts with the R4 latency.
- R8: While `rst_n` is low, no output runs. Each output shows the idle level selected for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 8 | Source clock of each output |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_pin_n | input | 3 | Active-low enable pins |
| link_mask | input | 24 | Pin-to-output links, bit p*8+o |
| idle_sel | input | 16 | Idle level per output, 2 bits each |
| pwr_dn | input | 8 | Per-output power-down |
| clk_out | output | 8 | Gated clock data per output |
| clk_drv_en | output | 8 | Drive enable for each output's tri-state buffer |

## Verification
On every source edge, the assertions check four things. A settled stop request shows exactly the configured idle level for the whole high phase. A settled start request yields a full high phase. No output is ever high in the low half of its clock unless it idles high. Power-down and reset keep outputs from running. Only the bench scenarios show the exact edge on which the first and last pulses appear, since the assertions accept any state while a request is still crossing the synchroniser. The same holds for many-to-many link patterns taken as whole vectors.

// File: rtl/oegate_pkg.sv
`timescale 1ns/1ps
package oegate_pkg;
    typedef enum logic [1:0] {
        IDLE_LOW   = 2'd0,
        IDLE_HIGH  = 2'd1,
        IDLE_FLOAT = 2'd2,
        IDLE_SPARE = 2'd3
    } idle_e;

    typedef struct packed {
        logic meta;
        logic held;
    } sync_t;
endpackage

// File: rtl/oeg_link_map.sv
`timescale 1ns/1ps
module oeg_link_map #(
    parameter int NPIN = 3,
    parameter int NOUT = 8,
    localparam int MASK_W = NPIN * NOUT
) (
    input  logic [NPIN-1:0]   oe_pin_n,
    input  logic [MASK_W-1:0] link_mask,
    input  logic [NOUT-1:0]   pwr_dn,
    output logic [NOUT-1:0]   stop_req
);
    // A high pin that is linked to an output votes to stop it; any vote wins.
    for (genvar o = 0; o < NOUT; o++) begin : g_out
        logic [NPIN-1:0] votes;
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            assign votes[p] = oe_pin_n[p] & link_mask[p*NOUT + o];
        end
        assign stop_req[o] = (|votes) | pwr_dn[o];
    end
endmodule

// File: rtl/oeg_lane.sv
`timescale 1ns/1ps
module oeg_lane
    import oegate_pkg::*;
(
    input  logic  src_clk,
    input  logic  rst_n,
    input  logic  stop_req,
    input  logic  pwr_dn,
    input  idle_e idle_sel,
    output logic  clk_out,
    output logic  drv_en
);
    sync_t sync_d, sync_q;
    logic  gate_d, gate_q;

    always_comb begin
        sync_d.meta = stop_req;
        sync_d.held = sync_q.meta;
        gate_d      = ~sync_q.held;
        if (pwr_dn) begin
            clk_out = 1'b0;
            drv_en  = 1'b0;
        end else if (gate_q) begin
            clk_out = src_clk;
            drv_en  = 1'b1;
        end else begin
            clk_out = (idle_sel == IDLE_HIGH);
            drv_en  = (idle_sel == IDLE_LOW) || (idle_sel == IDLE_HIGH);
        end
    end

    // Request crosses into the output domain on rising edges.
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{meta: 1'b1, held: 1'b1};
        else        sync_q <= sync_d;
    end

    // Gate changes only while the source is low, so pulses are never cut.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/mapped_clock_gate.sv
`timescale 1ns/1ps
module mapped_clock_gate
    import oegate_pkg::*;
#(
    parameter int NOUT = 8,
    parameter int NPIN = 3
) (
    input  logic [NOUT-1:0]      src_clk,
    input  logic                 rst_n,
    input  logic [NPIN-1:0]      oe_pin_n,
    input  logic [NPIN*NOUT-1:0] link_mask,
    input  logic [2*NOUT-1:0]    idle_sel,
    input  logic [NOUT-1:0]      pwr_dn,
    output logic [NOUT-1:0]      clk_out,
    output logic [NOUT-1:0]      clk_drv_en
);
    localparam int SEL_W = 2;

    logic [NOUT-1:0] stop_req;

    oeg_link_map #(.NPIN(NPIN), .NOUT(NOUT)) u_map (
        .oe_pin_n (oe_pin_n),
        .link_mask(link_mask),
        .pwr_dn   (pwr_dn),
        .stop_req (stop_req)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_lane
        oeg_lane u_lane (
            .src_clk (src_clk[g]),
            .rst_n   (rst_n),
            .stop_req(stop_req[g]),
            .pwr_dn  (pwr_dn[g]),
            .idle_sel(idle_e'(idle_sel[SEL_W*g +: SEL_W])),
            .clk_out (clk_out[g]),
            .drv_en  (clk_drv_en[g])
        );
    end
endmodule

// File: rtl/mapped_clock_gate_chk.sv
`timescale 1ns/1ps
module mapped_clock_gate_chk #(
    parameter int NOUT = 8,
    parameter int NPIN = 3
) (
    input logic [NOUT-1:0]      src_clk,
    input logic                 rst_n,
    input logic [NPIN-1:0]      oe_pin_n,
    input logic [NPIN*NOUT-1:0] link_mask,
    input logic [2*NOUT-1:0]    idle_sel,
    input logic [NOUT-1:0]      pwr_dn,
    input logic [NOUT-1:0]      clk_out,
    input logic [NOUT-1:0]      clk_drv_en
);
    logic [NOUT-1:0] want_off;

    always_comb begin
        want_off = pwr_dn;
        for (int o = 0; o < NOUT; o++) begin
            for (int p = 0; p < NPIN; p++) begin
                if (oe_pin_n[p] && link_mask[p*NOUT + o]) want_off[o] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_lane
        // R5/R6: a settled stop shows the idle level through the high phase
        a_r5_settled_stop_idles: assert property (@(negedge src_clk[g]) disable iff (!rst_n)
            (want_off[g] && $past(want_off[g]) && $past(want_off[g], 2) && $past(want_off[g], 3)
             && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && !pwr_dn[g])
            |-> (clk_out[g] == (idle_sel[2*g +: 2] == 2'd1))
                && (clk_drv_en[g] == (idle_sel[2*g +: 2] < 2'd2)));

        // R1/R4: a settled start yields a full high phase
        a_r4_settled_start_runs: assert property (@(negedge src_clk[g]) disable iff (!rst_n)
            (!want_off[g] && !$past(want_off[g]) && !$past(want_off[g], 2) && !$past(want_off[g], 3)
             && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
            |-> clk_out[g] && clk_drv_en[g]);

        // R6: nothing high in the low half unless idling high
        a_r6_low_half_quiet: assert property (@(posedge src_clk[g]) disable iff (!rst_n)
            (clk_drv_en[g] && idle_sel[2*g +: 2] != 2'd1) |-> !clk_out[g]);

        // R7: power-down keeps the pin released and low
        a_r7_pwr_dn_quiet: assert property (@(posedge src_clk[g]) disable iff (!rst_n)
            (pwr_dn[g] && $past(pwr_dn[g])) |-> (!clk_drv_en[g] && !clk_out[g]));

        // R8: under reset only the idle level appears
        a_r8_reset_idle: assert property (@(negedge src_clk[g])
            (!rst_n && !$past(rst_n))
            |-> clk_out[g] == ((idle_sel[2*g +: 2] == 2'd1) && !pwr_dn[g]));
    end
endmodule

bind mapped_clock_gate mapped_clock_gate_chk #(.NOUT(NOUT), .NPIN(NPIN)) u_chk (.*);

// File: tb/test_mapped_clock_gate.sv
`timescale 1ns/1ps
module test_mapped_clock_gate;
    localparam int NOUT = 8;
    localparam int NPIN = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      oe_pin_n = 3'b111;
    logic [23:0]     link_mask = 24'h0;
    logic [15:0]     idle_sel = 16'hE4E4;
    logic [7:0]      pwr_dn = 8'h0;
    logic [7:0]      src_clk;
    logic [7:0]      clk_out;
    logic [7:0]      clk_drv_en;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;
    assign src_clk = {NOUT{clk}};

    mapped_clock_gate #(.NOUT(NOUT), .NPIN(NPIN)) i_mapped_clock_gate (
        .src_clk(src_clk), .rst_n(rst_n), .oe_pin_n(oe_pin_n), .link_mask(link_mask),
        .idle_sel(idle_sel), .pwr_dn(pwr_dn), .clk_out(clk_out), .clk_drv_en(clk_drv_en)
    );

    // Vector: {pins[50:48], mask[47:24], idle[23:8], pd[7:0]}
    localparam logic [50:0] VEC [0:7] = '{
        {3'b000, 24'hFFFFFF, 16'hE4E4, 8'h00},  // R1 all run
        {3'b001, 24'hFFFFFF, 16'hE4E4, 8'h00},  // R1/R6 all stop
        {3'b001, 24'h00000F, 16'hE4E4, 8'h00},  // R2 partial links
        {3'b110, 24'hF00FFF, 16'hE4E4, 8'h00},  // R3 any pin wins
        {3'b100, 24'hF00FFF, 16'hE4E4, 8'h00},  // R3 one pin stops upper half
        {3'b000, 24'hFFFFFF, 16'hE4E4, 8'hA5},  // R7 power-down mix
        {3'b111, 24'h000000, 16'hE4E4, 8'h00},  // R2 no links run
        {3'b010, 24'h00FF00, 16'h5555, 8'h00}   // R6 idle high
    };

    // Codes: 0 run, 1 low, 2 high, 3 released
    function automatic int model(int o, logic [2:0] pin, logic [23:0] mask,
                                 logic [15:0] idle, logic [7:0] pd);
        logic off = 1'b0;
        logic [1:0] sel = idle[2*o +: 2];
        if (pd[o]) return 3;
        for (int p = 0; p < NPIN; p++) if (pin[p] && mask[p*NOUT + o]) off = 1'b1;
        if (!off) return 0;
        if (sel == 2'd0) return 1;
        if (sel == 2'd1) return 2;
        return 3;
    endfunction

    function automatic int code_of(logic hi, logic lo, logic oe);
        if (!oe) return 3;
        if (hi && !lo) return 0;
        if (!hi && !lo) return 1;
        if (hi && lo) return 2;
        return 4;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample(output logic [7:0] hi, output logic [7:0] lo, output logic [7:0] oe);
        @(posedge clk); #1;
        hi = clk_out; oe = clk_drv_en;
        @(negedge clk); #1;
        lo = clk_out;
    endtask

    task automatic apply(logic [50:0] v);
        @(negedge clk);
        oe_pin_n  = v[50:48];
        link_mask = v[47:24];
        idle_sel  = v[23:8];
        pwr_dn    = v[7:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] hi, lo, oe;
        // R8: reset keeps all outputs idle even with every pin enabling
        oe_pin_n = 3'b000; link_mask = 24'hFFFFFF;
        repeat (2) @(negedge clk);
        sample(hi, lo, oe);
        for (int o = 0; o < NOUT; o++)
            check("R8", code_of(hi[o], lo[o], oe[o]), model(o, 3'b111, 24'hFFFFFF, idle_sel, 8'h0), "reset idle");
        @(negedge clk); rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 8; i++) begin
            apply(VEC[i]);
            repeat (5) @(posedge clk);
            sample(hi, lo, oe);
            for (int o = 0; o < NOUT; o++)
                check($sformatf("R1/R2/R3/R6/R7 vec%0d out%0d", i, o), code_of(hi[o], lo[o], oe[o]),
                      model(o, VEC[i][50:48], VEC[i][47:24], VEC[i][23:8], VEC[i][7:0]), "state");
        end

        // R4: start latency on output 0 (idle low)
        apply({3'b001, 24'h000001, 16'hE4E4, 8'h00});
        repeat (5) @(posedge clk);
        @(negedge clk); oe_pin_n[0] = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1; check("R4", clk_out[0], 0, "no pulse after 2nd rise");
        @(posedge clk); #0.4; check("R4", clk_out[0], 1, "pulse start after 3rd rise");
        #1.4; check("R4", clk_out[0], 1, "pulse full width");

        // R5: stop completes in-flight pulses
        repeat (3) @(posedge clk);
        @(negedge clk); oe_pin_n[0] = 1'b1;
        @(posedge clk); #1; check("R5", clk_out[0], 1, "pulse after 1st rise");
        @(posedge clk); #0.4; check("R5", clk_out[0], 1, "pulse after 2nd rise");
        #1.4; check("R5", clk_out[0], 1, "last pulse full width");
        @(posedge clk); #1; check("R5", clk_out[0], 0, "idle after 3rd rise");
        check("R5", clk_drv_en[0], 1, "idle low driven");

        // R7: power-down while running, then restart latency
        @(negedge clk); oe_pin_n[0] = 1'b0;
        repeat (5) @(posedge clk);
        #0.5; pwr_dn[0] = 1'b1;
        #0.5; check("R7", {clk_drv_en[0], clk_out[0]}, 0, "immediate quiet");
        repeat (4) @(posedge clk);
        #1; check("R7", {clk_drv_en[0], clk_out[0]}, 0, "held quiet with pin enabling");
        @(negedge clk); pwr_dn[0] = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1; check("R7", {clk_drv_en[0], clk_out[0]}, 2, "still idle after 2nd rise");
        @(posedge clk); #1; check("R7", clk_out[0], 1, "restart after 3rd rise");

        // R6: released output is low with drive off
        apply({3'b001, 24'h000004, 16'hE4E4, 8'h00});
        repeat (5) @(posedge clk); #1;
        check("R6", {clk_drv_en[2], clk_out[2]}, 0, "released idle");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule